// File: doc/BRIEF.md
# Bit-Aligned Raster Block Combiner

This engine takes a rectangular patch of a one-bit-per-pixel image and merges it into another rectangle of the same image. Each destination pixel becomes a logical function of the source pixel and the destination's old value. The source and destination corners may fall on any bit, and the two corners need not share the same alignment. Both areas use one common row pitch.

Software or a host sequencer supplies two corner bit addresses, a width, a height, a pitch and a two-bit function code, then pulses `start`. The engine walks the rectangle one row at a time, from the top row downward, and moves left to right within each row. Each step handles one destination word. The engine reads the one or two source words that hold the needed bits, reads the destination word, merges the result under a mask, and writes the word back. A single-access memory port with a request/acknowledge handshake carries all traffic. A one-cycle `done` pulse marks the end of the operation.

Top module: `bitblt_engine`

## Requirements
- R1: Pixel (row r, column c) of an area lives at bit address base + r*pitch + c. Bit address a is bit a mod 16 of the 16-bit memory word at word address a div 16. Bit 0 is the least significant bit.
- R2: Function code 2'b00 writes the source bit into the destination.
- R3: Function code 2'b01 writes the source bit ANDed with the old destination bit.
- R4: Function code 2'b10 writes the source bit ORed with the old destination bit.
- R5: Function code 2'b11 writes the source bit XORed with the old destination bit.
- R6: Memory bits outside the destination rectangle keep their values, including bits in partially covered edge words. Each destination word touched in a row is written exactly once for that row.
- R7: When width or height is 0, `done` pulses in the cycle after `start` is sampled, and no memory write occurs.
- R8: `memReq` stays high, with `memAddr` and `memWe` unchanged, until the cycle in which `memAck` is seen. No access is requested while the engine is idle.
- R9: `done` is high for exactly one cycle. It follows the acknowledge of the final write.
- R10: Rows are processed top to bottom and words left to right, so destination write addresses never decrease within one operation.
- R11: Source and destination corners may sit at any bit offset, independently of each other, and any width from 1 upward is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled while idle) |
| srcBase | input | 20 | Source rectangle corner bit address |
| dstBase | input | 20 | Destination rectangle corner bit address |
| blitWidth | input | 12 | Rectangle width in bits |
| blitHeight | input | 12 | Rectangle height in rows |
| pitch | input | 20 | Bit distance between vertically adjacent pixels |
| opSel | input | 2 | Logical function code |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Word address |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access acknowledge; read data valid with it |
| memRdata | input | 16 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Directed cases cover the following:
- a zero width and a zero height, which separate the early exit from a real walk;
- a single-bit column, which exercises the narrowest mask;
- a word-aligned copy, in which the second source read is never needed;
- a wide run, with source and destination at different offsets, that crosses several words.

Each of the four function codes is then run against the same random background, so that a swapped or broken code shows up as a memory difference.

Random rectangles with random offsets, widths, heights and pitches cover the two-word source gather and the edge masks on both sides of a row. For every operation, the whole memory is compared against a bit-by-bit model, and the number of writes and their order are checked against the count derived from the rectangle geometry.

// File: rtl/bitblt_pkg.sv
package bitblt_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XOR  = 2'b11
  } blitOp_e;

  typedef enum logic [1:0] {
    SEL_SRC0 = 2'd0,
    SEL_SRC1 = 2'd1,
    SEL_DST  = 2'd2
  } memSel_e;

  typedef struct packed {
    logic    load;
    logic    capSrc0;
    logic    capSrc1;
    logic    capDst;
    logic    stepCol;
    logic    stepRow;
    memSel_e sel;
  } dpCtrl_t;

endpackage

// File: rtl/bitblt_dp.sv
module bitblt_dp
  import bitblt_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpCtrl_t                    ctl,
  input  logic [ADDR_W-1:0]          srcBaseIn,
  input  logic [ADDR_W-1:0]          dstBaseIn,
  input  logic [DIM_W-1:0]           widthIn,
  input  logic [DIM_W-1:0]           heightIn,
  input  logic [ADDR_W-1:0]          pitchIn,
  input  logic [1:0]                 opIn,
  input  logic [WORD_W-1:0]          memRdata,
  output logic [ADDR_W-$clog2(WORD_W)-1:0] memAddr,
  output logic [WORD_W-1:0]          memWdata,
  output logic                       needSrc1,
  output logic                       rowDone,
  output logic                       lastRow,
  output logic                       sizeZero
);

  localparam int OFF_W   = $clog2(WORD_W);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int CNT_W   = OFF_W + 1;

  logic [ADDR_W-1:0] srcRow, dstRow, pitchReg;
  logic [DIM_W-1:0]  widthReg, heightReg, colIdx, rowIdx;
  blitOp_e           opReg;
  logic [WORD_W-1:0] srcLo, srcHi, dstWord;

  logic [ADDR_W-1:0] curSrc, curDst;
  logic [OFF_W-1:0]  srcOff, dstOff;
  logic [CNT_W-1:0]  room, chunk;
  logic [DIM_W-1:0]  left;
  logic [CNT_W:0]    srcEnd;
  logic [2*WORD_W-1:0] pair, shifted;
  logic [WORD_W-1:0] aligned, onesN, mask, opRes;
  logic [WADDR_W-1:0] srcWordAddr;

  assign curSrc = srcRow + ADDR_W'(colIdx);
  assign curDst = dstRow + ADDR_W'(colIdx);
  assign srcOff = curSrc[OFF_W-1:0];
  assign dstOff = curDst[OFF_W-1:0];
  assign room   = CNT_W'(WORD_W) - CNT_W'(dstOff);
  assign left   = widthReg - colIdx;
  assign chunk  = (left < DIM_W'(room)) ? CNT_W'(left) : room;
  assign srcEnd = (CNT_W+1)'(srcOff) + (CNT_W+1)'(chunk);

  assign needSrc1 = srcEnd > (CNT_W+1)'(WORD_W);
  assign rowDone  = (colIdx + DIM_W'(chunk)) == widthReg;
  assign lastRow  = (rowIdx + DIM_W'(1)) == heightReg;
  assign sizeZero = (widthIn == '0) || (heightIn == '0);

  // gather source bits into destination alignment
  assign pair    = {srcHi, srcLo};
  assign shifted = pair >> srcOff;
  assign aligned = shifted[WORD_W-1:0] << dstOff;
  assign onesN   = {WORD_W{1'b1}} >> (CNT_W'(WORD_W) - chunk);
  assign mask    = onesN << dstOff;

  always_comb begin
    unique case (opReg)
      OP_COPY: opRes = aligned;
      OP_AND:  opRes = aligned & dstWord;
      OP_OR:   opRes = aligned | dstWord;
      default: opRes = aligned ^ dstWord;
    endcase
  end

  assign memWdata    = (dstWord & ~mask) | (opRes & mask);
  assign srcWordAddr = curSrc[ADDR_W-1:OFF_W];

  always_comb begin
    unique case (ctl.sel)
      SEL_SRC0: memAddr = srcWordAddr;
      SEL_SRC1: memAddr = srcWordAddr + WADDR_W'(1);
      default:  memAddr = curDst[ADDR_W-1:OFF_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srcRow <= '0; dstRow <= '0; pitchReg <= '0;
      widthReg <= '0; heightReg <= '0; colIdx <= '0; rowIdx <= '0;
      opReg <= OP_COPY; srcLo <= '0; srcHi <= '0; dstWord <= '0;
    end else begin
      if (ctl.load) begin
        srcRow    <= srcBaseIn;
        dstRow    <= dstBaseIn;
        pitchReg  <= pitchIn;
        widthReg  <= widthIn;
        heightReg <= heightIn;
        opReg     <= blitOp_e'(opIn);
        colIdx    <= '0;
        rowIdx    <= '0;
      end
      if (ctl.capSrc0) srcLo <= memRdata;
      if (ctl.capSrc1) srcHi <= memRdata;
      if (ctl.capDst)  dstWord <= memRdata;
      if (ctl.stepCol) colIdx <= colIdx + DIM_W'(chunk);
      if (ctl.stepRow) begin
        colIdx <= '0;
        rowIdx <= rowIdx + DIM_W'(1);
        srcRow <= srcRow + pitchReg;
        dstRow <= dstRow + pitchReg;
      end
    end
  end

  // R6: a merged word never reaches past the end of its memory word
  assert_chunk_in_word_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.stepCol || ctl.stepRow) |-> ((CNT_W+1)'(dstOff) + (CNT_W+1)'(chunk) <= (CNT_W+1)'(WORD_W)));

  // R1: the walk stays inside the loaded rectangle
  assert_walk_in_rect_R1: assert property (@(posedge clk) disable iff (rst)
    (widthReg != '0 && heightReg != '0) |-> (colIdx < widthReg && rowIdx < heightReg));

endmodule

// File: rtl/bitblt_ctrl.sv
module bitblt_ctrl
  import bitblt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    memAck,
  input  logic    needSrc1,
  input  logic    rowDone,
  input  logic    lastRow,
  input  logic    sizeZero,
  output dpCtrl_t ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    busy,
  output logic    done
);

  typedef enum logic [2:0] {IDLE, RDS0, RDS1, RDD, WRD, FIN} state_e;
  state_e state, nextState;

  assign memReq = (state == RDS0) || (state == RDS1) || (state == RDD) || (state == WRD);
  assign memWe  = (state == WRD);
  assign busy   = (state != IDLE);
  assign done   = (state == FIN);

  always_comb begin
    ctl       = '0;
    ctl.sel   = SEL_DST;
    nextState = state;
    unique case (state)
      IDLE: if (start) begin
        ctl.load  = 1'b1;
        nextState = sizeZero ? FIN : RDS0;
      end
      RDS0: begin
        ctl.sel     = SEL_SRC0;
        ctl.capSrc0 = memAck;
        if (memAck) nextState = needSrc1 ? RDS1 : RDD;
      end
      RDS1: begin
        ctl.sel     = SEL_SRC1;
        ctl.capSrc1 = memAck;
        if (memAck) nextState = RDD;
      end
      RDD: begin
        ctl.capDst = memAck;
        if (memAck) nextState = WRD;
      end
      WRD: if (memAck) begin
        if (rowDone && lastRow) nextState = FIN;
        else begin
          ctl.stepRow = rowDone;
          ctl.stepCol = !rowDone;
          nextState   = RDS0;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= IDLE;
    else     state <= nextState;
  end

  // R9: completion is entered only from the last write or a zero-size start
  assert_done_source_R9: assert property (@(posedge clk) disable iff (rst)
    (state == FIN) |-> ($past(state) == WRD || $past(state) == IDLE));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/bitblt_engine.sv
module bitblt_engine
  import bitblt_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12,
  parameter int WORD_W = 16,
  localparam int WADDR_W = ADDR_W - $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  srcBase,
  input  logic [ADDR_W-1:0]  dstBase,
  input  logic [DIM_W-1:0]   blitWidth,
  input  logic [DIM_W-1:0]   blitHeight,
  input  logic [ADDR_W-1:0]  pitch,
  input  logic [1:0]         opSel,
  output logic               memReq,
  output logic               memWe,
  output logic [WADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWdata,
  input  logic               memAck,
  input  logic [WORD_W-1:0]  memRdata,
  output logic               busy,
  output logic               done
);

  dpCtrl_t ctl;
  logic needSrc1, rowDone, lastRow, sizeZero;

  bitblt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .memAck(memAck),
    .needSrc1(needSrc1), .rowDone(rowDone), .lastRow(lastRow), .sizeZero(sizeZero),
    .ctl(ctl), .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );

  bitblt_dp #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .srcBaseIn(srcBase), .dstBaseIn(dstBase), .widthIn(blitWidth), .heightIn(blitHeight),
    .pitchIn(pitch), .opIn(opSel), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .needSrc1(needSrc1), .rowDone(rowDone), .lastRow(lastRow), .sizeZero(sizeZero)
  );

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !memReq);

  assert_zero_size_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (blitWidth == '0 || blitHeight == '0)) |=> (done && !memReq));

endmodule

// File: tb/bitblt_engine_bench.sv
module bitblt_engine_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [19:0] srcBase = '0, dstBase = '0, pitch = '0;
  logic [11:0] blitWidth = '0, blitHeight = '0;
  logic [1:0]  opSel = '0;
  logic        memReq, memWe, busy, done;
  logic [15:0] memAddr, memWdata;
  logic        memAck;
  logic [15:0] memRdata;

  bitblt_engine u_bitblt_engine (
    .clk(clk), .rst(rst), .start(start), .srcBase(srcBase), .dstBase(dstBase),
    .blitWidth(blitWidth), .blitHeight(blitHeight), .pitch(pitch), .opSel(opSel),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .busy(busy), .done(done)
  );

  logic [15:0] mem    [0:1023];
  logic [15:0] expMem [0:1023];
  int          wrCount, orderErrs;
  logic [15:0] lastWr;

  // memory model: ack one cycle after request
  always @(posedge clk) begin
    if (rst) begin
      memAck <= 1'b0; memRdata <= '0; wrCount <= 0; orderErrs <= 0; lastWr <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= 16'($urandom);
    end else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) begin
        if (memWe) begin
          mem[memAddr[9:0]] <= memWdata;
          wrCount <= wrCount + 1;
          if (memAddr < lastWr) orderErrs <= orderErrs + 1;
          lastWr <= memAddr;
        end else begin
          memRdata <= mem[memAddr[9:0]];
        end
      end
      if (start) lastWr <= '0;
    end
  end

  int vectors = 0;
  int miscompares = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit refOp(bit s, bit d, int op);
    case (op)
      0: return s;
      1: return s & d;
      2: return s | d;
      default: return s ^ d;
    endcase
  endfunction

  task automatic runBlit(int sb, int db, int w, int h, int p, int op, string req);
    int wr0, ord0, cyc, expWrites, bad, firstBad;
    for (int i = 0; i < 1024; i++) expMem[i] = mem[i];
    // bit-serial model in row-major order (R1..R5)
    expWrites = 0;
    for (int r = 0; r < h; r++) begin
      if (w > 0) expWrites += ((db + r*p + w - 1) >> 4) - ((db + r*p) >> 4) + 1;
      for (int c = 0; c < w; c++) begin
        int sa = sb + r*p + c;
        int da = db + r*p + c;
        bit sv = expMem[sa >> 4][sa & 15];
        bit dv = expMem[da >> 4][da & 15];
        expMem[da >> 4][da & 15] = refOp(sv, dv, op);
      end
    end
    if (w == 0) expWrites = 0;
    wr0 = wrCount; ord0 = orderErrs;
    @(negedge clk);
    srcBase = 20'(sb); dstBase = 20'(db); blitWidth = 12'(w); blitHeight = 12'(h);
    pitch = 20'(p); opSel = 2'(op); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R9", "done seen", done, 1);
    if (w == 0 || h == 0)
      check(cyc == 1, "R7", "cycles to done", cyc, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9", "done width one cycle", done, 0);
    bad = 0; firstBad = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== expMem[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    if (bad != 0)
      check(1'b0, req, $sformatf("memory word %0d", firstBad), mem[firstBad], expMem[firstBad]);
    else
      check(1'b1, req, "memory", 0, 0);
    check(wrCount - wr0 == expWrites, "R6", "write count", wrCount - wr0, expWrites);
    check(orderErrs == ord0, "R10", "write order", orderErrs - ord0, 0);
  endtask

  initial begin
    #(5ns * 150000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && memReq == 1'b0, "R8", "reset state",
          {busy, done, memReq}, 0);

    // R7: zero sizes
    runBlit(100, 9000, 0, 5, 40, 3, "R7");
    runBlit(100, 9000, 17, 0, 40, 3, "R7");
    // R11: single-bit column at odd offsets
    runBlit(37, 9011, 1, 6, 61, 0, "R11");
    // R2: word-aligned copy
    runBlit(320, 8192, 48, 4, 160, 0, "R2");
    // R3..R5 and R11: misaligned wide runs under each function code
    runBlit(5, 9003, 57, 3, 99, 1, "R3");
    runBlit(14, 9201, 40, 4, 77, 2, "R4");
    runBlit(250, 10009, 33, 5, 50, 3, "R5");
    runBlit(1, 8207, 16, 2, 16, 0, "R11");

    // random mix (R1, R6, R11)
    for (int k = 0; k < 60; k++) begin
      int w = 1 + int'($urandom % 60);
      int h = 1 + int'($urandom % 6);
      int p = w + int'($urandom % 100);
      int sb = int'($urandom % 7000);
      int db = 8192 + int'($urandom % 7000);
      runBlit(sb, db, w, h, p, int'($urandom % 4), "R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule